// File: doc/BRIEF.md
# Coprocessor local-memory DMA

This block moves 32-bit words between a large main memory and the 8 KB private memory of a coprocessor. The private memory is split into two 4 KB banks, and address bit 12 selects the bank. Software first writes a local byte address and a main-memory byte address into two configuration registers. It then writes a byte-length code to one of two start registers. The start register that is written selects the direction of the copy.

Before a transfer is launched, the block checks it against three rules. The main-memory address must lie within the configured memory size. The whole span must stay inside one local bank. The two addresses and the byte count must all be whole words. A request that breaks any rule moves no data and sets a sticky error flag instead. An accepted request copies one word per clock. Two views of the same busy state can be read back: a bit in the status register and a dedicated busy register.

Top module: `cop_lmem_dma`

## Requirements
- R1: A write to offset 0 keeps only the low 13 bits of the data as the local byte address. A write to offset 1 keeps only the low 29 bits as the main byte address. Reading the same offsets on `rd_addr` returns the masked values.
- R2: A write to offset 2 starts a main-to-local copy and a write to offset 3 starts a local-to-main copy. The low 12 bits of the data form a length code L, and the copy moves L+1 bytes, that is (L+1)/4 words. One word moves per clock, starting in the cycle after the start edge, with both word pointers rising by one each cycle from the programmed byte addresses divided by 4.
- R3: Status (offset 4) bit 0 and the busy register (offset 5) bit 0 both read 1 for exactly (L+1)/4 cycles of an accepted copy. Both read 0 after reset and after the copy ends.
- R4: A start whose main byte address (after masking) is greater than MAIN_BYTES moves no data, leaves busy at 0 and sets the error flag. An address equal to MAIN_BYTES is accepted.
- R5: A start where L+1 plus the low 12 bits of the local address is greater than 4096 moves no data, leaves busy at 0 and sets the error flag. A span that ends exactly at the bank end is accepted.
- R6: A start is rejected in the same way as R4 and R5 when the local address, the main address or L+1 is not a multiple of 4.
- R7: The error flag is status bit 1. It stays set across later accepted copies. It is cleared only by a write to offset 4 with data bit 1 at 1; a write to offset 4 with bit 1 at 0 leaves it unchanged.
- R8: A start write that arrives while busy reads 1, including in the cycle of the final word, is ignored. It moves no data, does not change the running copy and does not touch the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register offset of the write |
| cfg_wdata | input | 32 | Write data |
| rd_addr | input | 3 | Register offset to read |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| mm_addr | output | 27 | Main-memory word address |
| mm_we | output | 1 | Main-memory word write enable |
| mm_wdata | output | 32 | Main-memory write data |
| mm_rdata | input | 32 | Main-memory read data (same-cycle) |
| lm_addr | output | 11 | Local-memory word address |
| lm_we | output | 1 | Local-memory word write enable |
| lm_wdata | output | 32 | Local-memory write data |
| lm_rdata | input | 32 | Local-memory read data (same-cycle) |

## Verification
Two functions can land on the same clock edge: the transfer of the final word, which ends busy, and a new start write. The bench launches a four-word copy and times a second start so that it is sampled on the edge that moves the fourth word. That second start must be dropped: the busy indications fall, the memories hold only the first copy, and the error flag stays as it was. A second start issued in the middle of a long copy is judged the same way, by the per-cycle reference model and by the final comparison of both memories.

// File: rtl/cop_lmem_dma_pkg.sv
package cop_lmem_dma_pkg;
   localparam int DATA_W   = 32;
   localparam int WORD_LG  = 2;

   typedef enum logic {
      DIR_TO_LOCAL = 1'b0,
      DIR_TO_MAIN  = 1'b1
   } dir_e;

   localparam logic [2:0] OFS_LOC      = 3'd0;
   localparam logic [2:0] OFS_MAIN     = 3'd1;
   localparam logic [2:0] OFS_GO_LOCAL = 3'd2;
   localparam logic [2:0] OFS_GO_MAIN  = 3'd3;
   localparam logic [2:0] OFS_STAT     = 3'd4;
   localparam logic [2:0] OFS_BUSY     = 3'd5;
endpackage

// File: rtl/cop_lmem_dma_chk.sv
module cop_lmem_dma_chk
   import cop_lmem_dma_pkg::*;
#(
   parameter int          MAIN_AW    = 29,
   parameter int          BANK_AW    = 12,
   parameter int unsigned MAIN_BYTES = 32'h0080_0000,
   localparam int         CNT_W      = BANK_AW - 1
) (
   input  logic [MAIN_AW-1:0] main_i,
   input  logic [BANK_AW-1:0] loc_off_i,
   input  logic [BANK_AW-1:0] len_i,
   output logic               ok_o,
   output logic [CNT_W-1:0]   words_o
);
   localparam longint unsigned SPAN = 64'd1 << MAIN_AW;

   logic [BANK_AW:0]   nbytes;
   logic [BANK_AW+1:0] span_end;
   logic               in_range;
   logic               fits;
   logic               aligned;

   assign nbytes   = {1'b0, len_i} + 1'b1;
   assign span_end = {1'b0, nbytes} + {2'b00, loc_off_i};
   assign fits     = span_end <= (BANK_AW+2)'(64'd1 << BANK_AW);
   assign aligned  = (nbytes[WORD_LG-1:0] == '0) && (main_i[WORD_LG-1:0] == '0)
                     && (loc_off_i[WORD_LG-1:0] == '0);

   generate
      if (SPAN - 64'd1 <= 64'(MAIN_BYTES)) begin : g_range_open
         assign in_range = 1'b1;
      end else begin : g_range_cmp
         assign in_range = 32'(main_i) <= MAIN_BYTES;
      end
   endgenerate

   assign ok_o    = in_range && fits && aligned;
   assign words_o = nbytes[BANK_AW:WORD_LG];
endmodule

// File: rtl/cop_lmem_dma_eng.sv
module cop_lmem_dma_eng
   import cop_lmem_dma_pkg::*;
#(
   parameter int MW_W  = 27,
   parameter int LW_W  = 11,
   parameter int BW_W  = 10,
   parameter int CNT_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  dir_e              dir_i,
   input  logic [MW_W-1:0]   mw_i,
   input  logic [LW_W-1:0]   lw_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              busy_o,
   output logic [MW_W-1:0]   mm_addr_o,
   output logic              mm_we_o,
   output logic [DATA_W-1:0] mm_wdata_o,
   input  logic [DATA_W-1:0] mm_rdata_i,
   output logic [LW_W-1:0]   lm_addr_o,
   output logic              lm_we_o,
   output logic [DATA_W-1:0] lm_wdata_o,
   input  logic [DATA_W-1:0] lm_rdata_i
);
   logic             busy_q;
   dir_e             dir_q;
   logic [MW_W-1:0]  mptr_q;
   logic [LW_W-1:0]  lptr_q;
   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dir_q  <= DIR_TO_LOCAL;
         mptr_q <= '0;
         lptr_q <= '0;
         rem_q  <= '0;
      end else if (busy_q) begin
         mptr_q <= mptr_q + 1'b1;
         lptr_q <= lptr_q + 1'b1;
         rem_q  <= rem_q - 1'b1;
         if (rem_q == CNT_W'(1)) busy_q <= 1'b0;
      end else if (launch_i) begin
         busy_q <= 1'b1;
         dir_q  <= dir_i;
         mptr_q <= mw_i;
         lptr_q <= lw_i;
         rem_q  <= cnt_i;
      end
   end

   assign busy_o     = busy_q;
   assign mm_addr_o  = mptr_q;
   assign lm_addr_o  = lptr_q;
   assign mm_we_o    = busy_q && (dir_q == DIR_TO_MAIN);
   assign lm_we_o    = busy_q && (dir_q == DIR_TO_LOCAL);
   assign mm_wdata_o = lm_rdata_i;
   assign lm_wdata_o = mm_rdata_i;

   // R2: both pointers advance together, one word per busy cycle
   a_r2_walk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q || (lptr_q == $past(lptr_q) + 1'b1 && mptr_q == $past(mptr_q) + 1'b1));
   // R5: a running copy never leaves its bank
   a_r5_same_bank: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q || $stable(lptr_q[LW_W-1:BW_W]));
   // R3: busy ends right after the last word
   a_r3_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && rem_q == CNT_W'(1)) |=> !busy_q);
endmodule

// File: rtl/cop_lmem_dma.sv
module cop_lmem_dma
   import cop_lmem_dma_pkg::*;
#(
   parameter int          MAIN_AW    = 29,
   parameter int          LOCAL_AW   = 13,
   parameter int          BANK_AW    = 12,
   parameter int unsigned MAIN_BYTES = 32'h0080_0000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [2:0]                cfg_addr,
   input  logic [DATA_W-1:0]         cfg_wdata,
   input  logic [2:0]                rd_addr,
   output logic [DATA_W-1:0]         rd_data,
   output logic [MAIN_AW-WORD_LG-1:0]  mm_addr,
   output logic                      mm_we,
   output logic [DATA_W-1:0]         mm_wdata,
   input  logic [DATA_W-1:0]         mm_rdata,
   output logic [LOCAL_AW-WORD_LG-1:0] lm_addr,
   output logic                      lm_we,
   output logic [DATA_W-1:0]         lm_wdata,
   input  logic [DATA_W-1:0]         lm_rdata
);
   localparam int MW_W  = MAIN_AW - WORD_LG;
   localparam int LW_W  = LOCAL_AW - WORD_LG;
   localparam int BW_W  = BANK_AW - WORD_LG;
   localparam int CNT_W = BANK_AW - 1;

   generate
      if (MAIN_AW > DATA_W || MAIN_AW <= WORD_LG) begin : g_bad_main
         $error("MAIN_AW out of range");
      end
      if (BANK_AW >= LOCAL_AW || BANK_AW <= WORD_LG + 1) begin : g_bad_bank
         $error("BANK_AW must be below LOCAL_AW and above the word size");
      end
   endgenerate

   logic [LOCAL_AW-1:0] loc_q;
   logic [MAIN_AW-1:0]  main_q;
   logic [BANK_AW-1:0]  len_q;
   logic                err_q;
   logic                busy;
   logic                start_req;
   logic                chk_ok;
   logic [CNT_W-1:0]    words;
   logic                launch;
   logic                reject;
   logic                err_clr;
   dir_e                dir_req;
   logic                unused_cfg;

   assign start_req = cfg_we && (cfg_addr == OFS_GO_LOCAL || cfg_addr == OFS_GO_MAIN);
   assign dir_req   = (cfg_addr == OFS_GO_MAIN) ? DIR_TO_MAIN : DIR_TO_LOCAL;
   assign launch    = start_req && !busy && chk_ok;
   assign reject    = start_req && !busy && !chk_ok;
   assign err_clr   = cfg_we && (cfg_addr == OFS_STAT) && cfg_wdata[1];
   assign unused_cfg = ^cfg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_q  <= '0;
         main_q <= '0;
         len_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         if (cfg_we && cfg_addr == OFS_LOC)  loc_q  <= cfg_wdata[LOCAL_AW-1:0];
         if (cfg_we && cfg_addr == OFS_MAIN) main_q <= cfg_wdata[MAIN_AW-1:0];
         if (start_req && !busy)             len_q  <= cfg_wdata[BANK_AW-1:0];
         if (reject)                         err_q  <= 1'b1;
         else if (err_clr)                   err_q  <= 1'b0;
      end
   end

   cop_lmem_dma_chk #(
      .MAIN_AW   (MAIN_AW),
      .BANK_AW   (BANK_AW),
      .MAIN_BYTES(MAIN_BYTES)
   ) u_chk (
      .main_i   (main_q),
      .loc_off_i(loc_q[BANK_AW-1:0]),
      .len_i    (cfg_wdata[BANK_AW-1:0]),
      .ok_o     (chk_ok),
      .words_o  (words)
   );

   cop_lmem_dma_eng #(
      .MW_W (MW_W),
      .LW_W (LW_W),
      .BW_W (BW_W),
      .CNT_W(CNT_W)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch_i  (launch),
      .dir_i     (dir_req),
      .mw_i      (main_q[MAIN_AW-1:WORD_LG]),
      .lw_i      (loc_q[LOCAL_AW-1:WORD_LG]),
      .cnt_i     (words),
      .busy_o    (busy),
      .mm_addr_o (mm_addr),
      .mm_we_o   (mm_we),
      .mm_wdata_o(mm_wdata),
      .mm_rdata_i(mm_rdata),
      .lm_addr_o (lm_addr),
      .lm_we_o   (lm_we),
      .lm_wdata_o(lm_wdata),
      .lm_rdata_i(lm_rdata)
   );

   always_comb begin
      case (rd_addr)
         OFS_LOC:      rd_data = DATA_W'(loc_q);
         OFS_MAIN:     rd_data = DATA_W'(main_q);
         OFS_GO_LOCAL,
         OFS_GO_MAIN:  rd_data = DATA_W'(len_q);
         OFS_STAT:     rd_data = DATA_W'({err_q, busy});
         OFS_BUSY:     rd_data = DATA_W'(busy);
         default:      rd_data = '0;
      endcase
   end

   // R4 R5 R6: a rejected start never raises busy and always flags
   a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy && !chk_ok) |=> (!busy && err_q));
   // R7: the flag holds unless explicitly cleared
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr) |=> err_q);
   // R8: a start while busy leaves the flag alone
   a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && busy) |=> $stable(err_q));
   // R3: busy only rises from an accepted start
   a_r3_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(launch));
endmodule

// File: tb/sim_cop_lmem_dma.sv
module sim_cop_lmem_dma;
   import cop_lmem_dma_pkg::*;
   localparam int CLK_PERIOD = 10;
   localparam int MB         = 32'h4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [2:0]  rd_addr = OFS_STAT;
   logic [31:0] rd_data;
   logic [26:0] mm_addr;
   logic        mm_we;
   logic [31:0] mm_wdata, mm_rdata;
   logic [10:0] lm_addr;
   logic        lm_we;
   logic [31:0] lm_wdata, lm_rdata;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [31:0] dmm [4096];
   logic [31:0] dlm [2048];
   logic [31:0] rmm [4096];
   logic [31:0] rlm [2048];

   always #(CLK_PERIOD/2) clk = ~clk;

   cop_lmem_dma #(.MAIN_BYTES(MB)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
      .mm_addr(mm_addr), .mm_we(mm_we), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
      .lm_addr(lm_addr), .lm_we(lm_we), .lm_wdata(lm_wdata), .lm_rdata(lm_rdata)
   );

   assign mm_rdata = dmm[mm_addr[11:0]];
   assign lm_rdata = dlm[lm_addr];
   always @(posedge clk) begin
      if (mm_we) dmm[mm_addr[11:0]] <= mm_wdata;
      if (lm_we) dlm[lm_addr] <= lm_wdata;
   end

   // behavioural reference model
   int m_loc, m_main, m_len, m_rem, m_mp, m_lp, nb;
   bit m_busy, m_err, m_dir, was_busy;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_loc = 0; m_main = 0; m_len = 0; m_busy = 0; m_err = 0; m_dir = 0;
         m_rem = 0; m_mp = 0; m_lp = 0;
      end else begin
         was_busy = m_busy;
         if (m_busy) begin
            if (m_dir) rmm[m_mp & 4095] = rlm[m_lp & 2047];
            else       rlm[m_lp & 2047] = rmm[m_mp & 4095];
            m_mp++; m_lp++; m_rem--;
            if (m_rem == 0) m_busy = 0;
         end
         if (cfg_we) begin
            case (cfg_addr)
               3'd0: m_loc  = int'(cfg_wdata & 32'h1FFF);
               3'd1: m_main = int'(cfg_wdata & 32'h1FFF_FFFF);
               3'd2, 3'd3: if (!was_busy) begin
                  m_len = int'(cfg_wdata & 32'hFFF);
                  nb = m_len + 1;
                  if (m_main <= MB && nb + (m_loc % 4096) <= 4096 &&
                      m_loc % 4 == 0 && m_main % 4 == 0 && nb % 4 == 0) begin
                     m_busy = 1; m_rem = nb / 4; m_mp = m_main / 4; m_lp = m_loc / 4;
                     m_dir = (cfg_addr == 3'd3);
                  end else m_err = 1;
               end
               3'd4: if (cfg_wdata[1]) m_err = 0;
               default: ;
            endcase
         end
      end
   end

   task automatic fail(string req, longint act, longint exp);
      fails++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", req, act, exp, $time);
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         checks++;
         if (rd_data != {30'd0, m_err, m_busy}) fail("R3 status", rd_data, {m_err, m_busy});
         if (mm_we != (m_busy && m_dir)) fail("R2 mm_we", mm_we, m_busy && m_dir);
         if (lm_we != (m_busy && !m_dir)) fail("R2 lm_we", lm_we, m_busy && !m_dir);
         if (m_busy) begin
            if (mm_addr != 27'(m_mp)) fail("R2 mm_addr", mm_addr, m_mp);
            if (lm_addr != 11'(m_lp)) fail("R2 lm_addr", lm_addr, m_lp);
            if (m_dir && mm_wdata != rlm[m_lp & 2047]) fail("R2 mm_wdata", mm_wdata, rlm[m_lp & 2047]);
            if (!m_dir && lm_wdata != rmm[m_mp & 4095]) fail("R2 lm_wdata", lm_wdata, rmm[m_mp & 4095]);
         end
      end
   end

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic read_chk(logic [2:0] a, logic [31:0] exp, string req);
      @(negedge clk);
      rd_addr = a;
      #1;
      checks++;
      if (rd_data != exp) fail(req, rd_data, exp);
      rd_addr = OFS_STAT;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (m_busy);
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) cycles++;

   initial begin : stim
      for (int i = 0; i < 4096; i++) begin
         dmm[i] = 32'hA500_0000 ^ (i * 32'h0001_0203);
         rmm[i] = dmm[i];
      end
      for (int i = 0; i < 2048; i++) begin
         dlm[i] = 32'h3C00_0000 ^ (i * 32'h0007_0105);
         rlm[i] = dlm[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      read_chk(OFS_STAT, 32'd0, "R3 reset status");
      read_chk(OFS_BUSY, 32'd0, "R3 reset busy reg");

      // R1 masking
      wr(OFS_MAIN, 32'hE000_0100);
      read_chk(OFS_MAIN, 32'h0000_0100, "R1 main mask");
      wr(OFS_LOC, 32'hFFFF_F004);
      read_chk(OFS_LOC, 32'h0000_1004, "R1 local mask");

      // R2 main to local, 4 words
      wr(OFS_LOC, 32'h100); wr(OFS_MAIN, 32'h200); wr(OFS_GO_LOCAL, 32'd15);
      read_chk(OFS_BUSY, 32'd1, "R3 busy reg during copy");
      wait_idle();
      read_chk(OFS_BUSY, 32'd0, "R3 busy reg after copy");

      // R2 local to main, bank 1, 8 words
      wr(OFS_LOC, 32'h1000); wr(OFS_MAIN, 32'h800); wr(OFS_GO_MAIN, 32'd31);
      wait_idle();

      // R5 exact fit then overflow
      wr(OFS_LOC, 32'h0FF0); wr(OFS_MAIN, 32'h40); wr(OFS_GO_LOCAL, 32'd15);
      wait_idle();
      read_chk(OFS_STAT, 32'd0, "R5 exact bank end accepted");
      wr(OFS_GO_LOCAL, 32'd19);
      read_chk(OFS_STAT, 32'd2, "R5 bank overflow rejected");
      wr(OFS_STAT, 32'd2);
      read_chk(OFS_STAT, 32'd0, "R7 clear");

      // R4 range
      wr(OFS_LOC, 32'h20); wr(OFS_MAIN, MB + 4); wr(OFS_GO_MAIN, 32'd3);
      read_chk(OFS_STAT, 32'd2, "R4 above size rejected");
      wr(OFS_STAT, 32'd1);
      read_chk(OFS_STAT, 32'd2, "R7 write without bit1 keeps flag");
      wr(OFS_STAT, 32'd2);
      wr(OFS_MAIN, MB); wr(OFS_GO_MAIN, 32'd3);
      wait_idle();
      read_chk(OFS_STAT, 32'd0, "R4 equal to size accepted");

      // R6 alignment
      wr(OFS_LOC, 32'h2); wr(OFS_MAIN, 32'h4); wr(OFS_GO_LOCAL, 32'd3);
      read_chk(OFS_STAT, 32'd2, "R6 local misaligned");
      wr(OFS_STAT, 32'd2);
      wr(OFS_LOC, 32'h8); wr(OFS_GO_LOCAL, 32'd5);
      read_chk(OFS_STAT, 32'd2, "R6 length misaligned");
      wr(OFS_STAT, 32'd2);
      wr(OFS_MAIN, 32'h6); wr(OFS_GO_MAIN, 32'd7);
      read_chk(OFS_STAT, 32'd2, "R6 main misaligned");

      // R7 flag survives a good copy
      wr(OFS_MAIN, 32'h300); wr(OFS_GO_LOCAL, 32'd7);
      wait_idle();
      read_chk(OFS_STAT, 32'd2, "R7 sticky across copy");
      wr(OFS_STAT, 32'd2);

      // R8 start in the middle of a long copy
      wr(OFS_LOC, 32'h200); wr(OFS_MAIN, 32'h1000); wr(OFS_GO_MAIN, 32'd255);
      repeat (10) @(negedge clk);
      wr(OFS_GO_LOCAL, 32'd3);
      read_chk(OFS_BUSY, 32'd1, "R8 copy continues");
      wait_idle();
      read_chk(OFS_STAT, 32'd0, "R8 mid-copy start ignored");

      // R8 start on the final-word edge
      wr(OFS_LOC, 32'h400); wr(OFS_MAIN, 32'h2000); wr(OFS_GO_LOCAL, 32'd15);
      repeat (2) @(negedge clk);
      wr(OFS_GO_MAIN, 32'd3);
      read_chk(OFS_STAT, 32'd0, "R8 final-cycle start ignored");

      // R2 full bank, 1024 words
      wr(OFS_LOC, 32'h1000); wr(OFS_MAIN, 32'h0); wr(OFS_GO_LOCAL, 32'hFFF);
      wait_idle();
      read_chk(OFS_STAT, 32'd0, "R2 full bank done");

      checks++;
      for (int i = 0; i < 4096; i++)
         if (dmm[i] !== rmm[i]) fail("R2 main memory image", dmm[i], rmm[i]);
      checks++;
      for (int i = 0; i < 2048; i++)
         if (dlm[i] !== rlm[i]) fail("R2 local memory image", dlm[i], rlm[i]);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule